// File: doc/BRIEF.md
# Variable-Latency Corrected Approximate Adder

This block adds two unsigned operands with a speculative segmented adder and then makes the result exact. The operands are cut into equal segments. Each segment above the lowest guesses its carry-in from the segment directly below it alone, as if that lower segment had no carry-in of its own. This keeps the carry chain short, and in most cases the guess is right, so the exact sum appears one cycle after the operands are accepted.

The guess is wrong only when the segment below propagates across its full width while a real carry enters it. The block flags such segments with AND gates: the all-propagate term of the segment below is combined with the generate term of the segment two below. When any flag is set, the block stalls its input and repairs the sum with an incrementer. It fixes one segment per cycle, starting with the lowest flagged segment and moving upward. A carry out of a repaired segment schedules a repair of the segment above it. The result leaves with a flag that shows whether any repair was needed. As a result, the number of cycles per result depends on the operand values.

Top module: `var_lat_approx_adder`

## Requirements
- R1: During and straight after reset, outValid and outCorrected are low and inReady is high.
- R2: Every result presented with outValid high equals the exact (WIDTH+1)-bit sum inA+inB of the accepted pair, with bit WIDTH as the carry out.
- R3: A pair is accepted on a rising edge where inValid and inReady are both high. If no segment is flagged, outValid is high in the very next cycle and outCorrected is low.
- R4: Segment i covers bits [SEG*i +: SEG]. For i of 2 or more, it is flagged at acceptance when segment i-1 has every bit propagating (A xor B all ones) and segment i-2 generates a carry on its own. Segments 0 and 1 are never flagged. If any flag is set, inReady is low in the cycle after acceptance and the result carries outCorrected high.
- R5: The result appears 1+F cycles after acceptance. F is the number of segments i of 2 or more whose true carry-in differs from the carry-out of segment i-1 taken alone. The block repairs one segment per cycle, lowest first.
- R6: When incrementing a segment overflows, the segment above is repaired in the next cycle. When the top segment overflows, bit WIDTH of the sum is set.
- R7: inValid asserted while inReady is low is ignored. The pending result is unchanged and no extra result is produced.
- R8: Each accepted pair yields exactly one single-cycle outValid pulse. inReady returns high in the cycle that pulse is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Block can take a pair this cycle |
| inA | input | WIDTH | First operand |
| inB | input | WIDTH | Second operand |
| outValid | output | 1 | Result present (one cycle) |
| outSum | output | WIDTH+1 | Exact sum including carry out |
| outCorrected | output | 1 | High when the result needed repair |

## Verification
The repair of one segment and the scheduling of the segment above it happen in the same cycle. This occurs when an increment overflows. Operands such as 0x0FF8+0x0008 and 0xFFFF+0x0001 create a chain of all-propagate segments, so each repair ripples into the next one and finally into the carry-out bit. The bench predicts the latency and sum from exact carry arithmetic and compares both. A second overlap is a result being presented in the same cycle that inReady returns high. The bench keeps offering junk operands through the stall and checks that none of them leaks into the result or produces a second pulse.

// File: rtl/valadd_pkg.sv
package valadd_pkg;
  typedef struct packed {
    logic load;
    logic fix;
  } strobe_t;
endpackage

// File: rtl/valadd_datapath.sv
module valadd_datapath
  import valadd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             errAny,
  output logic             willClear,
  output logic [WIDTH:0]   sumQ,
  output logic             corrQ
);
  localparam int NSEG = WIDTH / SEG;
  localparam int IDXW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [NSEG-1:0] errVec, pendQ, pendAfter;
  logic [WIDTH:0]  approx, sumNext;
  logic [IDXW-1:0] fixIdx;
  logic [SEG:0]    incr;
  logic            found;

  // speculative sum: every segment guesses its carry-in from the one below alone
  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    if (g == 0) begin : gLow
      assign approx[SEG-1:0] = opA[SEG-1:0] + opB[SEG-1:0];
    end else begin : gHigh
      logic specCarry;
      assign specCarry = opA[(g-1)*SEG +: SEG] > ~opB[(g-1)*SEG +: SEG];
      if (g == NSEG - 1) begin : gTop
        assign approx[WIDTH:g*SEG] = {1'b0, opA[g*SEG +: SEG]} + {1'b0, opB[g*SEG +: SEG]}
                                   + {{SEG{1'b0}}, specCarry};
      end else begin : gMid
        assign approx[g*SEG +: SEG] = opA[g*SEG +: SEG] + opB[g*SEG +: SEG]
                                    + {{(SEG-1){1'b0}}, specCarry};
      end
    end
    // AND-gate detection: full propagate below, generate two below
    if (g < 2) begin : gNoErr
      assign errVec[g] = 1'b0;
    end else begin : gErr
      assign errVec[g] = (&(opA[(g-1)*SEG +: SEG] ^ opB[(g-1)*SEG +: SEG]))
                       & (opA[(g-2)*SEG +: SEG] > ~opB[(g-2)*SEG +: SEG]);
    end
  end

  assign errAny = |errVec;

  // repair step: increment lowest pending segment, pass overflow upward
  always_comb begin
    fixIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (pendQ[i] && !found) begin
        fixIdx = IDXW'(i);
        found  = 1'b1;
      end
    end
    incr      = {1'b0, sumQ[int'(fixIdx)*SEG +: SEG]} + (SEG+1)'(1);
    sumNext   = sumQ;
    sumNext[int'(fixIdx)*SEG +: SEG] = incr[SEG-1:0];
    pendAfter = pendQ;
    pendAfter[fixIdx] = 1'b0;
    if (incr[SEG] && found) begin
      if (int'(fixIdx) == NSEG - 1) sumNext[WIDTH] = 1'b1;
      else pendAfter[int'(fixIdx) + 1] = 1'b1;
    end
  end

  assign willClear = (pendAfter == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ  <= '0;
      pendQ <= '0;
      corrQ <= 1'b0;
    end else if (strobe.load) begin
      sumQ  <= approx;
      pendQ <= errVec;
      corrQ <= |errVec;
    end else if (strobe.fix) begin
      sumQ  <= sumNext;
      pendQ <= pendAfter;
    end
  end
endmodule

// File: rtl/valadd_control.sv
module valadd_control
  import valadd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    errAny,
  input  logic    willClear,
  output strobe_t strobe,
  output logic    inReady,
  output logic    outValid
);
  logic busyQ, validQ;

  assign inReady     = !busyQ;
  assign strobe.load = inValid && !busyQ;
  assign strobe.fix  = busyQ;
  assign outValid    = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      validQ <= 1'b0;
    end else if (strobe.load) begin
      busyQ  <= errAny;
      validQ <= !errAny;
    end else if (busyQ) begin
      busyQ  <= !willClear;
      validQ <= willClear;
    end else begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/var_lat_approx_adder.sv
module var_lat_approx_adder
  import valadd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  output logic             outValid,
  output logic [WIDTH:0]   outSum,
  output logic             outCorrected
);
  strobe_t strobe;
  logic    errAny, willClear;

  valadd_control ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .errAny(errAny),
    .willClear(willClear), .strobe(strobe), .inReady(inReady), .outValid(outValid)
  );

  valadd_datapath #(.WIDTH(WIDTH), .SEG(SEG)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(inA), .opB(inB),
    .errAny(errAny), .willClear(willClear), .sumQ(outSum), .corrQ(outCorrected)
  );
endmodule

// File: rtl/valadd_checker.sv
module valadd_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [WIDTH-1:0] inA,
  input logic [WIDTH-1:0] inB,
  input logic             outValid,
  input logic [WIDTH:0]   outSum,
  input logic             outCorrected
);
  logic           accept;
  logic [WIDTH:0] expQ;

  assign accept = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) expQ <= '0;
    else if (accept) expQ <= {1'b0, inA} + {1'b0, inB};
  end

  p_sum_exact_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outSum == expQ);

  p_accept_outcome_r3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (outValid || !inReady));

  p_fast_uncorrected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(accept)) |-> !outCorrected);

  p_slow_corrected_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(accept)) |-> outCorrected);

  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> outValid);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !accept) |=> !outValid);
endmodule

bind var_lat_approx_adder valadd_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inA(inA),
  .inB(inB), .outValid(outValid), .outSum(outSum), .outCorrected(outCorrected)
);

// File: tb/var_lat_approx_adder_tb_top.sv
module var_lat_approx_adder_tb_top;
  localparam int WIDTH = 16;
  localparam int SEG   = 4;
  localparam int NSEG  = WIDTH / SEG;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [WIDTH-1:0] inA = '0, inB = '0;
  logic             outValid;
  logic [WIDTH:0]   outSum;
  logic             outCorrected;
  int               checks = 0, failures = 0;
  bit               done = 0;

  always #2 clk = ~clk;

  var_lat_approx_adder #(.WIDTH(WIDTH), .SEG(SEG)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inA(inA),
    .inB(inB), .outValid(outValid), .outSum(outSum), .outCorrected(outCorrected)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int fixesFor(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    int cnt = 0;
    for (int i = 2; i < NSEG; i++) begin
      longint m  = (64'd1 << (SEG*i)) - 1;
      longint mk = (64'd1 << SEG) - 1;
      longint trueC = ((longint'(a) & m) + (longint'(b) & m)) >> (SEG*i);
      longint specC = (((longint'(a) >> (SEG*(i-1))) & mk)
                     + ((longint'(b) >> (SEG*(i-1))) & mk)) >> SEG;
      if (trueC != specC) cnt++;
    end
    return cnt;
  endfunction

  // one operation; junk=1 keeps offering other operands during the stall
  task automatic doOp(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, bit junk);
    int lat, fx;
    longint expSum;
    fx = fixesFor(a, b);
    expSum = longint'(a) + longint'(b);
    @(negedge clk);
    check(inReady == 1'b1, "R8", "ready before offer", longint'(inReady), 1);
    inValid = 1'b1; inA = a; inB = b;
    @(negedge clk);
    if (junk) begin inA = ~a; inB = b ^ 16'h5A5A; end
    else inValid = 1'b0;
    lat = 1;
    if (fx > 0) check(inReady == 1'b0, "R4", "ready low after flagged accept", longint'(inReady), 0);
    while (!outValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    inValid = 1'b0;
    check(lat == 1 + fx, "R5", "latency", lat, 1 + fx);
    check(longint'(outSum) == expSum, "R2", "sum", longint'(outSum), expSum);
    check(outCorrected == (fx > 0), fx > 0 ? "R4" : "R3", "corrected flag",
          longint'(outCorrected), longint'(fx > 0));
    @(negedge clk);
    check(outValid == 1'b0, junk ? "R7" : "R8", "no second pulse", longint'(outValid), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 0 && outCorrected == 0 && inReady == 1, "R1", "reset outputs",
          longint'({outValid, outCorrected, inReady}), 1);
  endtask

  task automatic testFastPath();   // R3: no flagged segment
    doOp(16'h1234, 16'h0101, 0);
    doOp(16'h0000, 16'h0000, 0);
    doOp(16'h0FF0, 16'h0000, 0);
  endtask

  task automatic testSingleFix();  // R4: one flagged segment
    doOp(16'h0FF0, 16'h0010, 0);
    check(fixesFor(16'h0FF0, 16'h0010) == 1, "R4", "model single", fixesFor(16'h0FF0, 16'h0010), 1);
  endtask

  task automatic testRipple();     // R6: overflow ripples upward and into carry out
    doOp(16'h0FF8, 16'h0008, 0);
    doOp(16'hFFFF, 16'h0001, 0);
    doOp(16'hFFFF, 16'hFFFF, 0);
    doOp(16'hF0F8, 16'h0F08, 0);
  endtask

  task automatic testStallIgnore(); // R7: junk offered while stalled
    doOp(16'hFFFF, 16'h0001, 1);
    doOp(16'h0FF0, 16'h0010, 1);
  endtask

  task automatic testBackToBack(); // R8: accept in presentation cycle
    int lat;
    @(negedge clk);
    inValid = 1'b1; inA = 16'h0FF0; inB = 16'h0010;
    @(negedge clk);
    inA = 16'h0102; inB = 16'h0304;
    lat = 1;
    while (!outValid && lat < 40) begin @(negedge clk); lat++; end
    check(outSum == 17'h01000, "R8", "first of pair", longint'(outSum), 'h1000);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1 && outSum == 17'h00406, "R8", "second accepted in present cycle",
          longint'(outSum), 'h406);
    @(negedge clk);
  endtask

  task automatic testRandom();     // R2 R5 over many patterns
    logic [31:0] lfsr = 32'hACE1_2461;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      doOp(lfsr[15:0], (n % 3 == 0) ? ~lfsr[31:16] : lfsr[31:16], n % 7 == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testFastPath();
    testSingleFix();
    testRipple();
    testStallIgnore();
    testBackToBack();
    testRandom();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule